// File: doc/BRIEF.md
# Complementary PWM Deadtime Inserter

This block sits after the compare logic of a paired PWM channel in combined mode. It takes two raw channel levels, for channel n and channel n+1, each already shaped by counter-compare matches. It returns two adjusted levels in which every move into the active state is postponed by a programmable guard interval. Moves into the inactive state are not postponed. The effect is that one channel of the pair has to let go before the other is allowed to drive. Each channel has its own polarity bit, which selects its active level. With polarity 0 the active level is high, so the delayed edge is a set. With polarity 1 the active level is low, so the delayed edge is a clear.

The guard is in force only when the combine-mode enable is high and the 4-bit deadtime code is non-zero. The guard length is the code times four clock cycles. When the guard is off, each output follows its raw level one registered cycle later. Each channel keeps its own down-counter. The counter is loaded when the raw level turns active. If the raw level turns inactive again before the count expires, the pending transition is dropped.

Top module: `dtins_pair`

## Requirements
- R1: When `comb_en` is 0 or `dt_val` is 0, each `pwm_out[i]` equals `raw_lvl[i]` as it was at the previous rising clock edge (one registered cycle of latency).
- R2: With the guard enabled, let raw channel i become active at rising edge t and stay active through edge t+D, where D = 4 × `dt_val`. Then the output turns active at edge t+D, and it is never active earlier.
- R3: Suppose the raw levels are never both active on the same edge, for example when they hand over in the same cycle. Then the two outputs are never both in their active states.
- R4: With `pol[i]` = 0 (active level high), channel i stays low through the guard after its raw level rises, and is then set high.
- R5: With `pol[i]` = 1 (active level low), channel i stays high through the guard after its raw level falls, and is then cleared low.
- R6: Each channel times its guard from its own raw edge, with its own counter and polarity, whatever the other channel is doing.
- R7: A raw move into the inactive state reaches the output at the next rising edge, with no added guard.
- R8: If the raw level returns to inactive before the guard expires, the pending transition is cancelled and the output stays inactive.
- R9: During reset and right after it, both outputs sit at their inactive level, which is equal to `pol[i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_lvl | input | 2 | Raw compare-derived levels; bit 0 is channel n, bit 1 is channel n+1 |
| pol | input | 2 | Polarity per channel; 0 means active high, 1 means active low |
| comb_en | input | 1 | Combined (complementary) mode enable |
| dt_val | input | 4 | Deadtime code; guard length is code × 4 clocks |
| pwm_out | output | 2 | Deadtime-adjusted channel levels, bit order as `raw_lvl` |

## Verification
The bench builds the block with its default parameters: a 4-bit code scaled by four. Every guard length from 4 to 60 cycles can then be reached, along with the zero code that falls back to plain one-cycle following. Random runs draw all sixteen codes and both polarities per channel. The raw toggle rates are chosen so that some active runs fall short of the guard and others outlast it. Directed cases exercise the largest code, a same-cycle handover between the two channels, and an aborted pulse.

// File: rtl/dtins_pkg.sv
package dtins_pkg;

  // guard length in clock cycles for a given code
  function automatic int unsigned dt_cycles(int unsigned code, int unsigned scale);
    return code * scale;
  endfunction

  // counter width that holds the longest guard
  function automatic int unsigned dt_cnt_width(int unsigned code_w, int unsigned scale);
    return code_w + $clog2(scale);
  endfunction

endpackage

// File: rtl/dtins_cfg.sv
module dtins_cfg #(
  parameter int DT_W     = 4,
  parameter int DT_SCALE = 4,
  parameter int CNT_W    = 6
) (
  input  logic             comb_en,
  input  logic [DT_W-1:0]  dt_val,
  output logic             dt_en,
  output logic [CNT_W-1:0] ld_val
);

  localparam int unsigned SCALE_U = DT_SCALE;

  logic [31:0] guard_len;

  assign dt_en     = comb_en && (dt_val != '0);
  assign guard_len = dtins_pkg::dt_cycles(int'(dt_val), SCALE_U);
  // counter is loaded with length-1 so the output moves exactly length edges later
  assign ld_val    = CNT_W'(guard_len - 32'd1);

endmodule

// File: rtl/dtins_chan.sv
module dtins_chan #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dt_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             raw_act,
  output logic             act,
  output logic             pend
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      pend  <= 1'b0;
      cnt_q <= '0;
    end else if (!dt_en) begin
      act   <= raw_act;
      pend  <= 1'b0;
      cnt_q <= '0;
    end else if (!raw_act) begin
      act   <= 1'b0;
      pend  <= 1'b0;
      cnt_q <= '0;
    end else if (act) begin
      act   <= 1'b1;
    end else if (!pend) begin
      pend  <= 1'b1;
      cnt_q <= ld_val;
    end else if (cnt_q == '0) begin
      act   <= 1'b1;
      pend  <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/dtins_pair.sv
module dtins_pair #(
  parameter int DT_W     = 4,
  parameter int DT_SCALE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      raw_lvl,
  input  logic [1:0]      pol,
  input  logic            comb_en,
  input  logic [DT_W-1:0] dt_val,
  output logic [1:0]      pwm_out
);

  localparam int NCH   = 2;
  localparam int CNT_W = int'(dtins_pkg::dt_cnt_width(DT_W, DT_SCALE));

  logic             dt_en;
  logic [CNT_W-1:0] ld_val;
  logic [NCH-1:0]   ract;
  logic [NCH-1:0]   act;
  logic [NCH-1:0]   pend;

  dtins_cfg #(.DT_W(DT_W), .DT_SCALE(DT_SCALE), .CNT_W(CNT_W)) u_cfg (
    .comb_en (comb_en),
    .dt_val  (dt_val),
    .dt_en   (dt_en),
    .ld_val  (ld_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // activity is polarity independent: 1 means the channel wants to drive
    assign ract[i] = raw_lvl[i] ^ pol[i];

    dtins_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .dt_en   (dt_en),
      .ld_val  (ld_val),
      .raw_act (ract[i]),
      .act     (act[i]),
      .pend    (pend[i])
    );

    assign pwm_out[i] = act[i] ^ pol[i];
  end

endmodule

// File: rtl/dtins_pair_chk.sv
module dtins_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dt_en,
  input logic [1:0] ract,
  input logic [1:0] act,
  input logic [1:0] pend
);

  // R1
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dt_en)) |-> (act == $past(ract)));

  // R7
  inactive_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((act & ~$past(ract)) == 2'b00));

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(ract) != 2'b11)) |-> (act != 2'b11));

  // R2
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dt_en)) |-> ((act & ~$past(act) & ~$past(pend)) == 2'b00));

  // R8
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dt_en)) |-> ((pend & ~$past(ract)) == 2'b00));

endmodule

bind dtins_pair dtins_pair_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .dt_en (dt_en),
  .ract  (ract),
  .act   (act),
  .pend  (pend)
);

// File: tb/dtins_pair_tb.sv
module dtins_pair_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] raw_lvl;
  logic [1:0] pol;
  logic       comb_en;
  logic [3:0] dt_val;
  logic [1:0] pwm_out;

  always #10 clk = ~clk;

  dtins_pair u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_lvl (raw_lvl),
    .pol     (pol),
    .comb_en (comb_en),
    .dt_val  (dt_val),
    .pwm_out (pwm_out)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model: consecutive active edges per channel, configuration seen at last edge
  int run0 = 0;
  int run1 = 0;
  bit en_q = 0;
  int d_q  = 0;

  function automatic int guard_of(logic [3:0] code);
    return int'(code) << 2;
  endfunction

  function automatic bit want_active(int r, bit en, int d);
    if (en) return r > d;
    return r > 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      run0 <= 0; run1 <= 0; en_q <= 0; d_q <= 0;
    end else begin
      run0 <= (raw_lvl[0] ^ pol[0]) ? run0 + 1 : 0;
      run1 <= (raw_lvl[1] ^ pol[1]) ? run1 + 1 : 0;
      en_q <= comb_en && (dt_val != 4'd0);
      d_q  <= guard_of(dt_val);
    end
  end

  task automatic check_ch(int ch, string tag);
    int  r;
    bit  a;
    logic expv;
    string t;
    r = (ch == 0) ? run0 : run1;
    a = want_active(r, en_q, d_q);
    expv = a ? ~pol[ch] : pol[ch];
    if (tag != "") t = tag;
    else if (!en_q) t = "R1";
    else if (a) t = pol[ch] ? "R5" : "R4";
    else if (r == 0) t = "R7";
    else t = "R2";
    checks++;
    if (pwm_out[ch] !== expv) begin
      errors++;
      $display("FAIL %s ch%0d actual %b expected %b", t, ch, pwm_out[ch], expv);
    end
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    check_ch(0, tag);
    check_ch(1, tag);
  endtask

  task automatic excl_check();
    bit a0, a1;
    a0 = pwm_out[0] ^ pol[0];
    a1 = pwm_out[1] ^ pol[1];
    checks++;
    if (a0 && a1) begin
      errors++;
      $display("FAIL R3 both active actual %b%b expected not 11", a1, a0);
    end
  endtask

  task automatic drive_act(bit a0, bit a1);
    raw_lvl = {a1, a0} ^ pol;
  endtask

  task automatic set_cfg(bit c, logic [3:0] v, logic [1:0] p);
    raw_lvl = pol;
    tick("R7");
    pol = p; raw_lvl = p; comb_en = c; dt_val = v;
    tick(""); tick("");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0d7e_11a5));
    rst_n = 0; raw_lvl = 2'b00; pol = 2'b00; comb_en = 0; dt_val = 0;
    repeat (3) tick("R9");
    pol = 2'b11; raw_lvl = 2'b11;
    tick("R9");
    @(negedge clk); rst_n = 1;
    tick("R9");

    // R1 bypass with combine off, then combine on with zero code
    set_cfg(0, 4'd5, 2'b00);
    for (int k = 0; k < 12; k++) begin drive_act(k % 3 == 0, k % 2 == 1); tick("R1"); end
    set_cfg(1, 4'd0, 2'b10);
    for (int k = 0; k < 12; k++) begin drive_act(k % 2 == 0, k % 5 != 0); tick("R1"); end

    // R4 polarity 0, D = 4
    set_cfg(1, 4'd1, 2'b00);
    drive_act(1, 0);
    repeat (10) tick("");
    // R5 polarity 1, D = 8
    set_cfg(1, 4'd2, 2'b11);
    drive_act(1, 1);
    repeat (14) tick("");

    // R8 pulse shorter than the guard (D = 12)
    set_cfg(1, 4'd3, 2'b01);
    drive_act(1, 0);
    repeat (6) tick("R8");
    drive_act(0, 0);
    repeat (20) tick("R8");

    // R3 same-cycle handover between the channels, D = 8
    set_cfg(1, 4'd2, 2'b01);
    for (int k = 0; k < 8; k++) begin
      drive_act(k % 2 == 0, k % 2 == 1);
      for (int j = 0; j < 15; j++) begin tick("R3"); excl_check(); end
    end

    // R6 channels started at different times with different polarity
    set_cfg(1, 4'd1, 2'b10);
    drive_act(1, 0);
    repeat (3) tick("R6");
    drive_act(1, 1);
    repeat (10) tick("R6");
    drive_act(0, 1);
    repeat (6) tick("R6");

    // R2 largest code, D = 60
    set_cfg(1, 4'd15, 2'b00);
    drive_act(1, 1);
    repeat (70) tick("R2");

    // random segments
    for (int s = 0; s < 40; s++) begin
      bit c;
      int rate;
      c = ($urandom % 4) != 0;
      set_cfg(c, 4'($urandom % 16), 2'($urandom % 4));
      rate = 4 + ($urandom % 28);
      for (int k = 0; k < 200; k++) begin
        bit f0, f1;
        f0 = ($urandom % rate) == 0;
        f1 = ($urandom % rate) == 0;
        raw_lvl = raw_lvl ^ {f1, f0};
        tick("");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule